// File: doc/BRIEF.md
# Multi-channel alarm indication signal detector

This block watches a set of independent channels (sixteen by default) for the alarm indication signal, a bearer that carries nothing but ones. Once per frame the upstream framer presents, for every channel in turn, the two 8-bit bearer bytes of that channel along with its channel number. The block checks both bytes together for all ones and keeps a per-channel run counter of consecutive all-ones frames. At one frame every 125 µs, 30 ms is 240 frames, so a channel whose bearer stays all ones for 240 frames in a row is declared in alarm.

On each detection the block writes one status entry into a small indication queue. The entry holds the channel number and a fixed event code. The queue raises an interrupt while it holds entries, unless the interrupt is masked. A channel reports once per alarm event and is re-armed only by a frame that is not all ones. A global enable turns all detection on or off. If the queue is full when a detection occurs, that entry is discarded and a sticky overflow flag is raised.

Top module: `ais_monitor`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1), `irq`=0 and `ovf`=0.
- R2: When a channel receives `PERSIST` (default 240) consecutive samples whose two bytes are both 8'hFF, one entry is queued: bits [3:0] hold the channel number and bits [7:4] hold the event code 4'hA.
- R3: A sample that is not all ones clears that channel's run, so `PERSIST`-1 all-ones samples, then a broken sample, then `PERSIST`-1 more produce no entry.
- R4: The 16 bits of the two bytes are judged jointly: a sample with any single bit at 0 in either byte counts as not all ones.
- R5: Channels are independent: samples on one channel never change the run count of another.
- R6: A channel reports at most once per unbroken all-ones run, however long it lasts; after one broken sample a fresh run of `PERSIST` samples reports again.
- R7: While `det_en`=0 no entry is produced and every run count is held at zero, so after re-enabling a channel needs a full `PERSIST` samples to report.
- R8: `irq` is 1 in the cycle after the queue is non-empty and `irq_mask`=0, and 0 otherwise.
- R9: With `FIFO_DEPTH` entries queued, a further detection is dropped, the stored entries are unchanged and `ovf` becomes 1 and stays 1 until reset.
- R10: Entries are read in the order of detection; within one frame, detections come out in the order the channels were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Global detection enable |
| irq_mask | input | 1 | Interrupt mask, 1 suppresses `irq` |
| smp_valid | input | 1 | A channel sample is presented this cycle |
| smp_chan | input | 4 | Channel number of the sample |
| smp_b1 | input | 8 | First bearer byte of the sample |
| smp_b2 | input | 8 | Second bearer byte of the sample |
| q_rd | input | 1 | Pop the head entry of the queue |
| q_data | output | 8 | Head entry: {event code, channel} |
| q_empty | output | 1 | Queue holds no entry |
| irq | output | 1 | Interrupt request |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The detector is driven with whole frames built from a per-channel pattern table: runs one sample short of the threshold followed by a break, runs that reach it exactly, and runs far longer than it, which tell a correct reset-on-break and single report apart from a counter that leaks or repeats. A sweep clears each of the sixteen bit positions in turn, one per channel, over a long run, which exposes a check that looks at only one byte or part of a byte. Mixed frames with several alarmed channels beside a channel that breaks periodically, a disabled stretch of all-ones traffic, and a burst of sixteen simultaneous detections into a four-entry queue separate channel crosstalk, enable handling, queue order and overflow dropping.

// File: rtl/ais_pkg.sv
package ais_pkg;
  localparam int          CODE_W  = 4;
  localparam logic [3:0]  EVT_AIS = 4'hA;
endpackage

// File: rtl/ais_chan_track.sv
// Per-channel run counters; registers a detection pulse when a channel's
// all-ones run reaches PERSIST samples.
module ais_chan_track #(
  parameter int NUM_CH  = 16,
  parameter int BYTE_W  = 8,
  parameter int PERSIST = 240,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W  = $clog2(PERSIST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic [BYTE_W-1:0] smp_b1,
  input  logic [BYTE_W-1:0] smp_b2,
  output logic              det_vld,
  output logic [CH_W-1:0]   det_chan
);
  logic              all_ones;
  logic [NUM_CH-1:0] hit;

  assign all_ones = &{smp_b1, smp_b2};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [CNT_W-1:0] run;
    logic             sel;

    assign sel = smp_valid && (smp_chan == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst || !en) begin
        run <= '0;
      end else if (sel) begin
        if (!all_ones)
          run <= '0;
        else if (run != CNT_W'(PERSIST))
          run <= run + 1'b1;
      end
    end

    assign hit[g] = sel && all_ones && (run == CNT_W'(PERSIST - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_vld  <= 1'b0;
      det_chan <= '0;
    end else begin
      det_vld  <= en && (|hit);
      det_chan <= smp_chan;
    end
  end
endmodule

// File: rtl/ais_evt_fifo.sv
// Small indication queue; drops pushes when full and flags it stickily.
module ais_evt_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok)
      mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ais_monitor.sv
module ais_monitor #(
  parameter int NUM_CH     = 16,
  parameter int BYTE_W     = 8,
  parameter int PERSIST    = 240,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ENTRY_W   = ais_pkg::CODE_W + CH_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               det_en,
  input  logic               irq_mask,
  input  logic               smp_valid,
  input  logic [CH_W-1:0]    smp_chan,
  input  logic [BYTE_W-1:0]  smp_b1,
  input  logic [BYTE_W-1:0]  smp_b2,
  input  logic               q_rd,
  output logic [ENTRY_W-1:0] q_data,
  output logic               q_empty,
  output logic               irq,
  output logic               ovf
);
  logic            det_vld;
  logic [CH_W-1:0] det_chan;
  logic            q_full;

  ais_chan_track #(
    .NUM_CH (NUM_CH),
    .BYTE_W (BYTE_W),
    .PERSIST(PERSIST)
  ) u_track (
    .clk      (clk),
    .rst      (rst),
    .en       (det_en),
    .smp_valid(smp_valid),
    .smp_chan (smp_chan),
    .smp_b1   (smp_b1),
    .smp_b2   (smp_b2),
    .det_vld  (det_vld),
    .det_chan (det_chan)
  );

  ais_evt_fifo #(
    .WIDTH(ENTRY_W),
    .DEPTH(FIFO_DEPTH)
  ) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (det_vld),
    .push_data({ais_pkg::EVT_AIS, det_chan}),
    .pop      (q_rd),
    .rd_data  (q_data),
    .empty    (q_empty),
    .full     (q_full),
    .ovf      (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= !irq_mask && !q_empty;
  end
endmodule

// File: rtl/ais_monitor_chk.sv
module ais_monitor_chk #(
  parameter int CH_W    = 4,
  parameter int ENTRY_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               det_en,
  input logic               irq_mask,
  input logic               irq,
  input logic               q_empty,
  input logic [ENTRY_W-1:0] q_data,
  input logic               q_rd,
  input logic               q_full,
  input logic               det_vld,
  input logic               ovf
);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(!q_empty && !irq_mask));

  // R7
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> !det_vld);

  // R2
  evt_code_chk: assert property (@(posedge clk) disable iff (rst)
    !q_empty |-> (q_data[CH_W +: ais_pkg::CODE_W] == ais_pkg::EVT_AIS));

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (q_full && det_vld && !q_rd) |=> (ovf && q_full));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind ais_monitor ais_monitor_chk #(
  .CH_W   (CH_W),
  .ENTRY_W(ENTRY_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .det_en  (det_en),
  .irq_mask(irq_mask),
  .irq     (irq),
  .q_empty (q_empty),
  .q_data  (q_data),
  .q_rd    (q_rd),
  .q_full  (q_full),
  .det_vld (det_vld),
  .ovf     (ovf)
);

// File: tb/ais_monitor_test.sv
`timescale 1ns/1ps
module ais_monitor_test;
  localparam int NCH  = 16;
  localparam int PER  = 240;
  localparam int DEP  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       det_en = 1'b1;
  logic       irq_mask = 1'b0;
  logic       smp_valid = 1'b0;
  logic [3:0] smp_chan = '0;
  logic [7:0] smp_b1 = '0;
  logic [7:0] smp_b2 = '0;
  logic       q_rd = 1'b0;
  logic [7:0] q_data;
  logic       q_empty, irq, ovf;

  int checks = 0;
  int errors = 0;
  logic [15:0] pat [NCH];

  always #10 clk = ~clk;

  ais_monitor uut (
    .clk(clk), .rst(rst), .det_en(det_en), .irq_mask(irq_mask),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_b1(smp_b1), .smp_b2(smp_b2),
    .q_rd(q_rd), .q_data(q_data), .q_empty(q_empty), .irq(irq), .ovf(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_all(input logic [15:0] w);
    for (int c = 0; c < NCH; c++) pat[c] = w;
  endtask

  // one frame: every channel presented in order 0..15, then one idle cycle
  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++) begin
      for (int c = 0; c < NCH; c++) begin
        @(negedge clk);
        smp_valid = 1'b1;
        smp_chan  = 4'(c);
        smp_b1    = pat[c][15:8];
        smp_b2    = pat[c][7:0];
      end
      @(negedge clk);
      smp_valid = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_expect(input string req, input int chan);
    @(negedge clk);
    check(req, int'(q_empty), 0);
    check(req, int'(q_data), int'({4'hA, 4'(chan)}));
    q_rd = 1'b1;
    @(negedge clk);
    q_rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_all(16'h0000);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", int'(q_empty), 1);
    check("R1 irq", int'(irq), 0);
    check("R1 ovf", int'(ovf), 0);

    // R3 one short of threshold, break, one short again
    pat[5] = 16'hFFFF;
    run_frames(PER - 1);
    pat[5] = 16'hFF00;
    run_frames(1);
    check("R3 no entry after broken run", int'(q_empty), 1);
    pat[5] = 16'hFFFF;
    run_frames(PER - 1);
    check("R3 run restarted after break", int'(q_empty), 1);
    // R2 one more sample reaches threshold
    run_frames(1);
    check("R2 entry present", int'(q_empty), 0);
    check("R8 irq unmasked", int'(irq), 1);
    irq_mask = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 irq masked", int'(irq), 0);
    irq_mask = 1'b0;
    repeat (2) @(negedge clk);
    pop_expect("R2 channel 5 entry", 5);
    check("R8 irq low when empty", int'(irq), 0);

    // R6 long run gives no second report; break and rerun reports again
    run_frames(300);
    check("R6 single report per run", int'(q_empty), 1);
    pat[5] = 16'h0000;
    run_frames(1);
    pat[5] = 16'hFFFF;
    run_frames(PER);
    pop_expect("R6 re-armed report", 5);
    check("R6 queue drained", int'(q_empty), 1);

    // R4 sweep: channel c has bit c cleared across both bytes
    for (int c = 0; c < NCH; c++) pat[c] = ~(16'h1 << c);
    run_frames(PER + 10);
    check("R4 single zero bit blocks detection", int'(q_empty), 1);

    // R5 / R10: channels 3, 9, 12 alarmed, channel 6 breaks periodically
    set_all(16'h0000);
    run_frames(1);
    pat[3] = 16'hFFFF; pat[9] = 16'hFFFF; pat[12] = 16'hFFFF;
    for (int k = 0; k < 3; k++) begin
      pat[6] = 16'hFFFF;
      run_frames(79);
      pat[6] = 16'hFEFF;
      run_frames(1);
    end
    check("R5 independence", int'(q_empty), 0);
    pop_expect("R10 order first ch3", 3);
    pop_expect("R10 order second ch9", 9);
    pop_expect("R10 order third ch12", 12);
    check("R5 ch6 broken run gave no entry", int'(q_empty), 1);

    // R7 disabled: nothing reported, counts held at zero
    set_all(16'h0000);
    run_frames(1);
    det_en = 1'b0;
    set_all(16'hFFFF);
    run_frames(300);
    check("R7 no entry while disabled", int'(q_empty), 1);
    set_all(16'h0000);
    pat[2] = 16'hFFFF;
    det_en = 1'b1;
    run_frames(PER - 1);
    check("R7 full run needed after enable", int'(q_empty), 1);
    run_frames(1);
    pop_expect("R7 report after enable", 2);

    // R9 sixteen simultaneous detections into a four-entry queue
    set_all(16'h0000);
    run_frames(1);
    check("R9 ovf clear before burst", int'(ovf), 0);
    set_all(16'hFFFF);
    run_frames(PER);
    check("R9 ovf set", int'(ovf), 1);
    for (int c = 0; c < DEP; c++) pop_expect("R9 kept entries R10 order", c);
    check("R9 extra entries dropped", int'(q_empty), 1);
    check("R9 ovf sticky", int'(ovf), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule